// File: doc/BRIEF.md
# Pattern-Table ADC Scan Sequencer

This block paces a continuous analog-to-digital scan. A host loads scan entries one at a time. Each entry carries a unit code, a channel number and an attenuation setting. The sequencer files each entry into the table of the unit it names, keeping arrival order, and counts the length of each table on its own.

Once started, the sequencer emits conversion trigger strobes at a fixed pace. With each strobe it presents the table entry the converter should use. The unit-interleave mode chooses which table or tables feed each trigger: unit 1 only, unit 2 only, both units together, or the units in turn. An optional conversion limit ends the run after a programmed number of trigger events. Otherwise the run lasts until the host stops it or clears the tables.

The block also drives a data-path enable for the downstream capture logic. Whenever a run ends, that enable drops one cycle after triggering has ceased.

Top module: `adc_scan_seq`

## Requirements
- R1: An accepted entry with `load_unit` = 0 is appended to table 1 and one with `load_unit` = 1 to table 2, in arrival order. `tbl_len1` and `tbl_len2` count each table's entries separately.
- R2: An entry with `load_unit` of 2 or 3, or aimed at a table that already holds DEPTH entries, changes neither table. `load_rej` pulses high for the one cycle after it.
- R3: Mode 0 triggers only unit 1 and mode 1 triggers only unit 2. A trigger event that selects an empty table produces no strobe.
- R4: Each table's read position starts at entry 0 and advances one entry per trigger of its unit. After the last loaded entry it wraps back to entry 0.
- R5: While running, trigger events are spaced 2*`ivl` clock cycles apart: a half-rate tick is divided by `ivl`. An `ivl` of 0 behaves as 1.
- R6: Mode 2 strobes `trig_u1` and `trig_u2` in the same cycle. Each unit carries the current entry of its own table.
- R7: Mode 3 triggers unit 1 first after a start and then switches unit on every trigger. If only one table holds entries, every trigger uses that table.
- R8: With `lim_en` high, `busy` falls on the edge that issues the `lim_num`-th trigger event (a `lim_num` of 0 acts as 1), and no further strobes follow. With `lim_en` low, the run continues until it is stopped.
- R9: `stop` or `tbl_clear` drops `busy` on the next edge, and no strobe is issued on that edge. `dp_en` falls exactly one cycle after `busy` falls, whatever ended the run.
- R10: `tbl_clear` sets both table lengths to zero and stops triggering.
- R11: `start` (ignored when `stop` or `tbl_clear` is high in the same cycle) rewinds both tables to entry 0, resets the conversion count and sets `busy` and `dp_en`.
- R12: Each strobe is one cycle wide. `u1_chan`/`u1_att` and `u2_chan`/`u2_att` update with their strobe and hold the last triggered entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Entry present this cycle |
| load_unit | input | 2 | Unit code of the entry (0 = unit 1, 1 = unit 2) |
| load_chan | input | 4 | Channel of the entry |
| load_att | input | 2 | Attenuation of the entry |
| tbl_clear | input | 1 | Empty both tables and end the run |
| load_rej | output | 1 | Pulse: last entry was refused |
| tbl_len1 | output | LEN_W | Entries held in table 1 |
| tbl_len2 | output | LEN_W | Entries held in table 2 |
| mode | input | 2 | 0 unit 1, 1 unit 2, 2 both, 3 alternate |
| ivl | input | IVL_W | Trigger spacing in half-rate ticks |
| lim_en | input | 1 | Enable the conversion limit |
| lim_num | input | LIM_W | Trigger events allowed per run |
| start | input | 1 | Begin a run from entry 0 |
| stop | input | 1 | End the run |
| busy | output | 1 | Triggering enabled |
| dp_en | output | 1 | Data path enable |
| trig_u1 | output | 1 | Conversion strobe for unit 1 |
| u1_chan | output | 4 | Channel of the last unit 1 trigger |
| u1_att | output | 2 | Attenuation of the last unit 1 trigger |
| trig_u2 | output | 1 | Conversion strobe for unit 2 |
| u2_chan | output | 4 | Channel of the last unit 2 trigger |
| u2_att | output | 2 | Attenuation of the last unit 2 trigger |

## Verification
The bench goes after the table-wrap point. A design that compares the index against the wrong bound would repeat an entry or read past the last loaded one, and the channel sequence would show it. It feeds unit codes 2 and 3, and loads a full table. Either stimulus would bump a length or overwrite an entry if routing were loose. In alternate mode the bench checks both the start unit and the case with an empty partner table; a design with the wrong fallback would issue empty strobes or stall. It also checks the count at which the limit ends the run, and that no strobe escapes on a stop edge. Finally, it checks that the data-path enable lags triggering by one cycle; reversing the order would lose the final sample.

// File: rtl/adc_seq_pkg.sv
// Shared types of the scan sequencer: entry layout and interleave modes.
// Assumes a 4-bit channel and a 2-bit attenuation field per entry.
package adc_seq_pkg;
    localparam int ENT_CH_W  = 4;
    localparam int ENT_ATT_W = 2;

    typedef enum logic [1:0] {
        MODE_U1   = 2'd0,
        MODE_U2   = 2'd1,
        MODE_BOTH = 2'd2,
        MODE_ALT  = 2'd3
    } scan_mode_e;

    typedef struct packed {
        logic [ENT_CH_W-1:0]  chan;
        logic [ENT_ATT_W-1:0] att;
    } scan_ent_t;
endpackage

// File: rtl/adc_seq_table.sv
// One per-unit pattern table: appends entries in order, counts its length and
// walks a read index that wraps to entry 0 after the last loaded entry.
// Assumes DEPTH >= 2; writes to a full table are dropped by this module.
module adc_seq_table
    import adc_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  scan_ent_t        wr_ent,
    input  logic             rewind,
    input  logic             adv,
    output logic [LEN_W-1:0] len,
    output logic             full,
    output scan_ent_t        cur_ent
);
    scan_ent_t        mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] idx_ext;

    assign full    = (len == LEN_W'(DEPTH));
    assign idx_ext = LEN_W'(idx) + LEN_W'(1);
    assign cur_ent = mem[idx];

    // Entry storage: append at the current length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && !full && !clr) begin
            mem[len[IDX_W-1:0]] <= wr_ent;
        end
    end

    // Length counter: cleared by clr, bumped by each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         len <= '0;
        else if (wr_en && !full)   len <= len + LEN_W'(1);
    end

    // Read index: rewinds on start or clear, wraps after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || rewind) idx <= '0;
        else if (adv) begin
            if (idx_ext >= len) idx <= '0;
            else                idx <= idx_ext[IDX_W-1:0];
        end
    end

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        len <= LEN_W'(DEPTH)); // R2
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (len == '0)); // R10
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (len != '0) |-> (LEN_W'(idx) < len)); // R4
endmodule

// File: rtl/adc_seq_pacer.sv
// Trigger pacer: halves the clock into a tick, then counts ivl ticks per
// trigger event. Held idle while run is low so each run starts aligned.
// Assumes ivl may change between runs; ivl of 0 is treated as 1.
module adc_seq_pacer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IVL_W-1:0] ivl,
    output logic             tick
);
    logic             half;
    logic [IVL_W-1:0] cnt;
    logic [IVL_W-1:0] ivl_m1;
    logic             at_end;

    assign ivl_m1 = (ivl == '0) ? '0 : ivl - IVL_W'(1);
    assign at_end = (cnt >= ivl_m1);
    assign tick   = run && half && at_end;

    // Half-rate phase and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            half <= 1'b0;
            cnt  <= '0;
        end else begin
            half <= ~half;
            if (half) cnt <= at_end ? '0 : cnt + IVL_W'(1);
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer top: routes loaded entries to two unit tables, paces trigger
// events, selects units by interleave mode, applies the conversion limit and
// sequences the stop (triggering off first, data path one cycle later).
// Assumes the host holds mode, ivl and the limit steady during a run.
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IVL_W = 16,
    parameter int LIM_W = 16,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_valid,
    input  logic [1:0]           load_unit,
    input  logic [ENT_CH_W-1:0]  load_chan,
    input  logic [ENT_ATT_W-1:0] load_att,
    input  logic                 tbl_clear,
    output logic                 load_rej,
    output logic [LEN_W-1:0]     tbl_len1,
    output logic [LEN_W-1:0]     tbl_len2,
    input  logic [1:0]           mode,
    input  logic [IVL_W-1:0]     ivl,
    input  logic                 lim_en,
    input  logic [LIM_W-1:0]     lim_num,
    input  logic                 start,
    input  logic                 stop,
    output logic                 busy,
    output logic                 dp_en,
    output logic                 trig_u1,
    output logic [ENT_CH_W-1:0]  u1_chan,
    output logic [ENT_ATT_W-1:0] u1_att,
    output logic                 trig_u2,
    output logic [ENT_CH_W-1:0]  u2_chan,
    output logic [ENT_ATT_W-1:0] u2_att
);
    localparam int NUNIT = 2;

    scan_ent_t        new_ent;
    scan_ent_t        ent_a [NUNIT];
    logic [LEN_W-1:0] len_a [NUNIT];
    logic [NUNIT-1:0] wr_a, adv_a, full_a, has_a, use_u;
    logic             load_ok, rej_nx, start_ok, tick, tick_ok, fire, last;
    logic             alt_sel;
    logic [LIM_W-1:0] conv_cnt;
    logic [LIM_W:0]   cnt_nx;
    scan_ent_t        out1, out2;
    scan_mode_e       mode_e;

    assign new_ent  = '{chan: load_chan, att: load_att};
    assign load_ok  = load_valid && !tbl_clear;
    assign start_ok = start && !stop && !tbl_clear;
    assign mode_e   = scan_mode_e'(mode);

    // Entry routing by unit code and refusal of bad codes or full tables.
    always_comb begin
        wr_a[0] = load_ok && (load_unit == 2'd0) && !full_a[0];
        wr_a[1] = load_ok && (load_unit == 2'd1) && !full_a[1];
        rej_nx  = load_ok && (load_unit[1] || full_a[load_unit[0]]);
    end

    generate
        for (genvar u = 0; u < NUNIT; u++) begin : g_tbl
            adc_seq_table #(.DEPTH(DEPTH)) u_tbl (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (tbl_clear),
                .wr_en   (wr_a[u]),
                .wr_ent  (new_ent),
                .rewind  (start_ok),
                .adv     (adv_a[u]),
                .len     (len_a[u]),
                .full    (full_a[u]),
                .cur_ent (ent_a[u])
            );
        end
    endgenerate

    assign tbl_len1 = len_a[0];
    assign tbl_len2 = len_a[1];

    adc_seq_pacer #(.IVL_W(IVL_W)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .ivl   (ivl),
        .tick  (tick)
    );

    // Unit selection for the current trigger event, per interleave mode.
    always_comb begin
        for (int u = 0; u < NUNIT; u++) has_a[u] = (len_a[u] != '0);
        use_u = '0;
        unique case (mode_e)
            MODE_U1:   use_u[0] = has_a[0];
            MODE_U2:   use_u[1] = has_a[1];
            MODE_BOTH: use_u    = has_a;
            MODE_ALT: begin
                if (!alt_sel) use_u = has_a[0] ? 2'b01 : (has_a[1] ? 2'b10 : 2'b00);
                else          use_u = has_a[1] ? 2'b10 : (has_a[0] ? 2'b01 : 2'b00);
            end
            default:   use_u = '0;
        endcase
    end

    assign tick_ok = tick && !stop && !tbl_clear;
    assign adv_a   = tick_ok ? use_u : '0;
    assign fire    = |adv_a;
    assign cnt_nx  = {1'b0, conv_cnt} + (LIM_W+1)'(1);
    assign last    = lim_en && (cnt_nx >= {1'b0, lim_num});

    // Run state: start sets it; stop, clear or the limit end it.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy <= 1'b0;
        else if (stop || tbl_clear) busy <= 1'b0;
        else if (start_ok)         busy <= 1'b1;
        else if (fire && last)     busy <= 1'b0;
    end

    // Data path enable trails the end of triggering by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        dp_en <= 1'b0;
        else if (start_ok) dp_en <= 1'b1;
        else if (!busy)    dp_en <= 1'b0;
    end

    // Conversion counter and alternate-mode unit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            conv_cnt <= '0;
            alt_sel  <= 1'b0;
        end else if (fire) begin
            conv_cnt <= cnt_nx[LIM_W-1:0];
            if (mode_e == MODE_ALT) alt_sel <= adv_a[0];
        end
    end

    // Registered strobes and held entry outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_u1 <= 1'b0;
            trig_u2 <= 1'b0;
            out1    <= '0;
            out2    <= '0;
            load_rej <= 1'b0;
        end else begin
            trig_u1  <= adv_a[0];
            trig_u2  <= adv_a[1];
            load_rej <= rej_nx;
            if (adv_a[0]) out1 <= ent_a[0];
            if (adv_a[1]) out2 <= ent_a[1];
        end
    end

    assign u1_chan = out1.chan;
    assign u1_att  = out1.att;
    assign u2_chan = out2.chan;
    assign u2_att  = out2.att;

    AST_REJ_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_rej |-> $past(load_valid)); // R2
    AST_U1_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        trig_u2 |-> ($past(mode) != 2'd0)); // R3
    AST_PAIR_ONLY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_u1 && trig_u2) |-> ($past(mode) == 2'd2)); // R6
    AST_TRIG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_u1 || trig_u2) |-> $past(busy)); // R9
    AST_DP_TRAILS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dp_en) |-> !$past(busy)); // R9
    AST_DP_HELD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> dp_en); // R9
    AST_CLEAR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clear |=> !busy); // R10
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    import adc_seq_pkg::*;

    localparam int DEPTH = 8;
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_valid = 1'b0;
    logic [1:0] load_unit = '0;
    logic [3:0] load_chan = '0;
    logic [1:0] load_att = '0;
    logic tbl_clear = 1'b0;
    logic load_rej;
    logic [LEN_W-1:0] tbl_len1, tbl_len2;
    logic [1:0] mode = '0;
    logic [15:0] ivl = 16'd1;
    logic lim_en = 1'b0;
    logic [15:0] lim_num = '0;
    logic start = 1'b0, stop = 1'b0;
    logic busy, dp_en, trig_u1, trig_u2;
    logic [3:0] u1_chan, u2_chan;
    logic [1:0] u1_att, u2_att;

    int total = 0, bad = 0, cycles = 0;
    int ev_n;
    int ev_t [32];
    logic ev_u1 [32], ev_u2 [32];
    int ev_c1 [32], ev_c2 [32], ev_a1 [32];
    logic last_rej;

    always #4 clk = ~clk;

    adc_scan_seq #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_unit(load_unit),
        .load_chan(load_chan), .load_att(load_att), .tbl_clear(tbl_clear),
        .load_rej(load_rej), .tbl_len1(tbl_len1), .tbl_len2(tbl_len2), .mode(mode),
        .ivl(ivl), .lim_en(lim_en), .lim_num(lim_num), .start(start), .stop(stop),
        .busy(busy), .dp_en(dp_en), .trig_u1(trig_u1), .u1_chan(u1_chan),
        .u1_att(u1_att), .trig_u2(trig_u2), .u2_chan(u2_chan), .u2_att(u2_att)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] att_of(input int ch);
        return 2'(ch) ^ 2'b01;
    endfunction

    task automatic load(input logic [1:0] u, input int ch);
        @(negedge clk);
        load_valid = 1'b1; load_unit = u; load_chan = 4'(ch); load_att = att_of(ch);
        @(negedge clk);
        load_valid = 1'b0;
        last_rej = load_rej;
    endtask

    task automatic pulse_clear();
        @(negedge clk); tbl_clear = 1'b1;
        @(negedge clk); tbl_clear = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        @(negedge clk);
    endtask

    task automatic grab(input int n);
        int cyc = 0;
        ev_n = 0;
        while (ev_n < n && cyc < 3000) begin
            @(negedge clk); cyc++;
            if (trig_u1 || trig_u2) begin
                ev_t[ev_n] = cyc; ev_u1[ev_n] = trig_u1; ev_u2[ev_n] = trig_u2;
                ev_c1[ev_n] = int'(u1_chan); ev_c2[ev_n] = int'(u2_chan);
                ev_a1[ev_n] = int'(u1_att);
                ev_n++;
            end
        end
        chk(ev_n == n, "R5 trigger count", ev_n, n);
    endtask

    task automatic quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (trig_u1 || trig_u2) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic test_reset();
        chk(!busy && !dp_en && !trig_u1 && !trig_u2, "R9 reset idle", int'(busy), 0);
        chk(tbl_len1 == 0 && tbl_len2 == 0, "R10 reset lengths", int'(tbl_len1), 0);
    endtask

    task automatic test_load();
        pulse_clear();
        load(2'd0, 1); chk(!last_rej, "R1 accept u1", int'(last_rej), 0);
        load(2'd1, 9);
        load(2'd0, 2);
        load(2'd2, 5); chk(last_rej, "R2 reject code 2", int'(last_rej), 1);
        load(2'd0, 3);
        load(2'd1, 10);
        load(2'd3, 6); chk(last_rej, "R2 reject code 3", int'(last_rej), 1);
        chk(tbl_len1 == 3, "R1 len1", int'(tbl_len1), 3);
        chk(tbl_len2 == 2, "R1 len2", int'(tbl_len2), 2);
    endtask

    task automatic test_u1();
        int exp_c [7] = '{1, 2, 3, 1, 2, 3, 1};
        mode = 2'd0; ivl = 16'd3;
        pulse_start();
        grab(7);
        for (int i = 0; i < 7; i++) begin
            chk(ev_u1[i] && !ev_u2[i], "R3 unit 1 only", int'(ev_u2[i]), 0);
            chk(ev_c1[i] == exp_c[i], "R4 u1 order and wrap", ev_c1[i], exp_c[i]);
            if (i > 0) chk(ev_t[i] - ev_t[i-1] == 6, "R5 spacing ivl=3", ev_t[i] - ev_t[i-1], 6);
        end
        chk(ev_a1[1] == int'(att_of(2)), "R12 att carried", ev_a1[1], int'(att_of(2)));
        pulse_stop();
    endtask

    task automatic test_u2();
        int exp_c [5] = '{9, 10, 9, 10, 9};
        mode = 2'd1; ivl = 16'd1;
        pulse_start();
        grab(5);
        for (int i = 0; i < 5; i++) begin
            chk(ev_u2[i] && !ev_u1[i], "R3 unit 2 only", int'(ev_u1[i]), 0);
            chk(ev_c2[i] == exp_c[i], "R4 u2 order and wrap", ev_c2[i], exp_c[i]);
            if (i > 0) chk(ev_t[i] - ev_t[i-1] == 2, "R5 spacing ivl=1", ev_t[i] - ev_t[i-1], 2);
        end
        pulse_stop();
    endtask

    task automatic test_both();
        int e1 [4] = '{1, 2, 3, 1};
        int e2 [4] = '{9, 10, 9, 10};
        mode = 2'd2; ivl = 16'd2;
        pulse_start();
        grab(4);
        for (int i = 0; i < 4; i++) begin
            chk(ev_u1[i] && ev_u2[i], "R6 paired strobes", int'(ev_u2[i]), 1);
            chk(ev_c1[i] == e1[i] && ev_c2[i] == e2[i], "R6 per-unit entries", ev_c2[i], e2[i]);
        end
        pulse_stop();
    endtask

    task automatic test_alt();
        int eu [6] = '{1, 2, 1, 2, 1, 2};
        int ec [6] = '{1, 9, 2, 10, 3, 9};
        mode = 2'd3; ivl = 16'd1;
        pulse_start();
        grab(6);
        for (int i = 0; i < 6; i++) begin
            int u = ev_u1[i] ? 1 : 2;
            int c = ev_u1[i] ? ev_c1[i] : ev_c2[i];
            chk(!(ev_u1[i] && ev_u2[i]) && u == eu[i], "R7 alternate unit", u, eu[i]);
            chk(c == ec[i], "R7 alternate entry", c, ec[i]);
        end
        pulse_stop();
    endtask

    task automatic test_ivl0();
        mode = 2'd0; ivl = 16'd0;
        pulse_start();
        grab(3);
        chk(ev_t[2] - ev_t[1] == 2, "R5 ivl 0 as 1", ev_t[2] - ev_t[1], 2);
        pulse_stop();
        ivl = 16'd1;
    endtask

    task automatic test_limit();
        int hits = 0, fell_at = -1, seen_dp_hold = 0;
        mode = 2'd0; ivl = 16'd1; lim_en = 1'b1; lim_num = 16'd5;
        pulse_start();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (trig_u1) hits++;
            if (fell_at < 0 && !busy) begin
                fell_at = i;
                seen_dp_hold = dp_en;
                chk(trig_u1, "R8 busy falls with last trigger", int'(trig_u1), 1);
                @(negedge clk);
                chk(!dp_en, "R9 dp_en one cycle later", int'(dp_en), 0);
            end
        end
        chk(hits == 5, "R8 limit count", hits, 5);
        chk(seen_dp_hold == 1, "R9 dp_en held at busy fall", seen_dp_hold, 1);
        lim_num = 16'd0;
        pulse_start();
        grab(1);
        quiet(30, "R8 lim_num 0 acts as 1");
        lim_en = 1'b0;
    endtask

    task automatic test_stop();
        mode = 2'd0; ivl = 16'd1;
        pulse_start();
        grab(2);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(!busy && dp_en, "R9 busy off dp on", int'(dp_en), 1);
        chk(!trig_u1, "R9 no strobe on stop edge", int'(trig_u1), 0);
        @(negedge clk);
        chk(!dp_en, "R9 dp off next", int'(dp_en), 0);
        quiet(20, "R8 stays stopped");
    endtask

    task automatic test_clear_run();
        mode = 2'd3; ivl = 16'd1;
        pulse_start();
        grab(1);
        @(negedge clk); tbl_clear = 1'b1;
        @(negedge clk); tbl_clear = 1'b0;
        chk(tbl_len1 == 0 && tbl_len2 == 0, "R10 lengths zero", int'(tbl_len1) + int'(tbl_len2), 0);
        chk(!busy, "R10 triggering off", int'(busy), 0);
        quiet(20, "R10 no strobes after clear");
    endtask

    task automatic test_alt_empty();
        int ec [4] = '{4, 5, 4, 5};
        load(2'd0, 4); load(2'd0, 5);
        mode = 2'd3; ivl = 16'd1;
        pulse_start();
        grab(4);
        for (int i = 0; i < 4; i++)
            chk(ev_u1[i] && !ev_u2[i] && ev_c1[i] == ec[i], "R7 empty partner", ev_c1[i], ec[i]);
        pulse_stop();
        mode = 2'd1;
        pulse_start();
        quiet(20, "R3 empty table silent");
        pulse_stop();
        mode = 2'd0;
        pulse_start();
        grab(2);
        pulse_stop();
        pulse_start();
        grab(1);
        chk(ev_c1[0] == 4, "R11 restart from entry 0", ev_c1[0], 4);
        pulse_stop();
    endtask

    task automatic test_full();
        pulse_clear();
        for (int i = 0; i < DEPTH; i++) load(2'd0, i + 1);
        chk(!last_rej, "R2 last fitting entry", int'(last_rej), 0);
        load(2'd0, 15);
        chk(last_rej, "R2 full table refuses", int'(last_rej), 1);
        chk(tbl_len1 == DEPTH, "R2 length capped", int'(tbl_len1), DEPTH);
        mode = 2'd0; ivl = 16'd1;
        pulse_start();
        grab(DEPTH + 1);
        chk(ev_c1[DEPTH-1] == DEPTH, "R2 last entry kept", ev_c1[DEPTH-1], DEPTH);
        chk(ev_c1[DEPTH] == 1, "R4 wrap at full depth", ev_c1[DEPTH], 1);
        pulse_stop();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_load();
        test_u1();
        test_u2();
        test_both();
        test_alt();
        test_ivl0();
        test_limit();
        test_stop();
        test_clear_run();
        test_alt_empty();
        test_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule